// File: doc/BRIEF.md
# Bus Parity Error Capture Logger

This block sits beside a node's interface to a wide system bus and keeps a record of bus errors for software. Each bus transaction has a command/address cycle and data cycles, and both are split into longwords. Every longword carries its own parity check. The parity checker outside the block raises one error pulse per longword. The logger sorts each error by phase (command/address, read data, fill write data) and by half. Even longwords go to the low half and odd longwords go to the high half. It records the error in sticky status bits and freezes the command and address of the first failing transaction in that half's capture register.

After the first capture, a half stays locked until software clears every summary bit that holds it. A later error in a locked half still sets its summary bit, and it also raises a separate missed bit, so the captured command and address are never overwritten. Read-only per-longword indicators show which longwords failed. The block also logs this node's own transactions that went unacknowledged. It flags a bus retry that arrives while retry is disabled, and answers that retry with a one-cycle hard-error acknowledge toward the processor.

Software reads the status vector and the two capture registers. It clears status bits by writing ones through the CSR write port.

Top module: `bpel_logger`

## Requirements
- R1: After reset every status bit, indicator, capture register and `hard_err_ack` is 0. A CSR write clears each status bit written as 1. A status bit written as 0, or any bit while `csr_we` is low, keeps its value. A new event in the same cycle as a clear leaves the bit set.
- R2: Status bit positions are fixed. Low half: 0 C/A error, 1 C/A missed, 2 read error, 3 read missed, 4 write error, 5 write missed. The high half uses the same order at bits 6 to 11. Bit 12 is C/A not-acked, bit 13 is write-data not-acked and bit 14 is retry failed. Errors on even longwords (0, 2) go to the low half and `cap_lo_*`. Errors on odd longwords (1, 3) go to the high half and `cap_hi_*`.
- R3: A parity error on any longword of a C/A cycle (`ca_valid`) is logged, with no condition on which node is commander. A free half captures `ca_cmd`/`ca_addr` in the same cycle.
- R4: An error in a half whose capture register is occupied sets that kind's error bit and missed bit. The captured command and address stay unchanged.
- R5: `ca_lw_flag[i]` marks a failed C/A longword i. `d_lw_flag[b*4+j]` marks a failed longword j of data beat b (beat 0 is the first data cycle, beat 1 the second). A C/A indicator stays set until its half's C/A error bit is cleared. A data indicator stays set until both its half's read and write error bits are clear.
- R6: A half's capture register is occupied while any of its three error bits is set (the low half also counts bits 12 and 13). Clearing these bits frees it, and the next error is captured.
- R7: A data-cycle parity error is logged as a read error only when `d_is_rd` is set, and as a write error only when `d_is_fill` is set. With neither set, the error changes no status bit, indicator or capture.
- R8: Data errors capture the command and address of the most recent `ca_valid` cycle before the data cycle.
- R9: When errors of several kinds hit one half in one cycle, capture goes to C/A first, then read, then write. Each kind that loses sets its missed bit.
- R10: `nack_ca` sets bit 12 and `nack_wd` sets bit 13. Into a free low capture, `nack_ca` stores command 0 with the last C/A address, and `nack_wd` stores the last C/A command and address. Neither sets a missed bit.
- R11: `retry_seen` while `retry_en` is low sets bit 14 and drives `hard_err_ack` high for exactly the next cycle. With `retry_en` high it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ca_valid | input | 1 | Command/address cycle strobe |
| ca_cmd | input | CMD_W | Command on the bus in the C/A cycle |
| ca_addr | input | ADDR_W | Address on the bus in the C/A cycle |
| ca_perr | input | LW | Per-longword parity error, C/A cycle |
| d_valid | input | 1 | Data cycle strobe |
| d_beat | input | BEAT_W | Data beat index (0 = first) |
| d_perr | input | LW | Per-longword parity error, data cycle |
| d_is_rd | input | 1 | Data is read return to this node as commander |
| d_is_fill | input | 1 | Data is write data accepted for a cache update |
| nack_ca | input | 1 | Own C/A cycle was not acknowledged |
| nack_wd | input | 1 | Own write-data octaword was not acknowledged |
| retry_seen | input | 1 | Bus retry observed |
| retry_en | input | 1 | Retry permitted |
| csr_we | input | 1 | Status write strobe |
| csr_wdata | input | 15 | Write-one-to-clear mask |
| status | output | 15 | Sticky status vector |
| ca_lw_flag | output | LW | Failed C/A longword indicators |
| d_lw_flag | output | LW*NBEAT | Failed data longword indicators |
| cap_lo_cmd | output | CMD_W | Low-half captured command |
| cap_lo_addr | output | ADDR_W | Low-half captured address |
| cap_hi_cmd | output | CMD_W | High-half captured command |
| cap_hi_addr | output | ADDR_W | High-half captured address |
| hard_err_ack | output | 1 | Hard-error acknowledge pulse to the processor |

## Verification
Assertions check these rules on every cycle:
- status bits stay sticky when no write is made;
- C/A errors on even lanes always raise the low C/A bit;
- an occupied low capture never changes without a clear;
- a low C/A indicator never outlives its summary bit;
- untagged data cycles never raise the read bit;
- the hard-error acknowledge follows exactly the disabled retries.

Only the bench scenarios can show the rest: the exact capture contents, same-cycle priority between kinds, beat-to-indicator mapping, capture release after a clear, and the command value stored on an unacknowledged C/A.

// File: rtl/bpel_pkg.sv
package bpel_pkg;
  // Per-half status layout: kind*2 is the error bit, kind*2+1 the missed bit
  localparam int KIND_CA   = 0;
  localparam int KIND_RD   = 1;
  localparam int KIND_WR   = 2;
  localparam int NKIND     = 3;
  localparam int PER_HALF  = 2 * NKIND;
  localparam int ST_NACK_CA = 2 * PER_HALF;
  localparam int ST_NACK_WD = ST_NACK_CA + 1;
  localparam int ST_RETRY   = ST_NACK_WD + 1;
  localparam int ST_W       = ST_RETRY + 1;

  function automatic int err_bit(input int h, input int kind);
    return h * PER_HALF + kind * 2;
  endfunction

  function automatic int miss_bit(input int h, input int kind);
    return h * PER_HALF + kind * 2 + 1;
  endfunction

  // Sticky write-one-to-clear update; a new event wins over a clear
  function automatic logic w1c(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/bpel_sticky.sv
module bpel_sticky #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        q[i] <= bpel_pkg::w1c(q[i], set[i], clr[i]);
      end
    end
  end
endmodule

// File: rtl/bpel_flags.sv
module bpel_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] hold,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= set | (flags & hold);
  end
endmodule

// File: rtl/bpel_half.sv
module bpel_half #(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        hit,       // {wr, rd, ca}
  input  logic              ext_hit,   // no-ack capture request
  input  logic              ext_busy,  // no-ack bits hold this half
  input  logic [CMD_W-1:0]  ca_cmd,
  input  logic [ADDR_W-1:0] ca_addr,
  input  logic [CMD_W-1:0]  tx_cmd,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [CMD_W-1:0]  ext_cmd,
  input  logic [2:0]        clr_err,
  input  logic [2:0]        clr_miss,
  output logic [2:0]        err,
  output logic [2:0]        miss,
  output logic              busy,
  output logic [CMD_W-1:0]  cap_cmd,
  output logic [ADDR_W-1:0] cap_addr
);
  logic       free;
  logic [2:0] take;
  logic [2:0] lost;
  logic       take_ext;

  // Fixed priority: C/A, then read, then write, then no-ack
  function automatic logic [2:0] grant(input logic [2:0] req, input logic ok);
    logic [2:0] g;
    g[0] = ok & req[0];
    g[1] = ok & req[1] & ~req[0];
    g[2] = ok & req[2] & ~req[1] & ~req[0];
    return g;
  endfunction

  assign busy     = (|err) | ext_busy;
  assign free     = ~busy;
  assign take     = grant(hit, free);
  assign lost     = hit & ~take;
  assign take_ext = ext_hit & free & ~(|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err  <= '0;
      miss <= '0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        err[k]  <= bpel_pkg::w1c(err[k],  hit[k],  clr_err[k]);
        miss[k] <= bpel_pkg::w1c(miss[k], lost[k], clr_miss[k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cmd  <= '0;
      cap_addr <= '0;
    end else if (take[0]) begin
      cap_cmd  <= ca_cmd;
      cap_addr <= ca_addr;
    end else if (take[1] | take[2]) begin
      cap_cmd  <= tx_cmd;
      cap_addr <= tx_addr;
    end else if (take_ext) begin
      cap_cmd  <= ext_cmd;
      cap_addr <= tx_addr;
    end
  end
endmodule

// File: rtl/bpel_logger.sv
module bpel_logger #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int LW     = 4,
  parameter int NBEAT  = 2,
  localparam int BEAT_W = (NBEAT > 1) ? $clog2(NBEAT) : 1,
  localparam int DLW    = LW * NBEAT,
  localparam int ST_W   = bpel_pkg::ST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ca_valid,
  input  logic [CMD_W-1:0]  ca_cmd,
  input  logic [ADDR_W-1:0] ca_addr,
  input  logic [LW-1:0]     ca_perr,
  input  logic              d_valid,
  input  logic [BEAT_W-1:0] d_beat,
  input  logic [LW-1:0]     d_perr,
  input  logic              d_is_rd,
  input  logic              d_is_fill,
  input  logic              nack_ca,
  input  logic              nack_wd,
  input  logic              retry_seen,
  input  logic              retry_en,
  input  logic              csr_we,
  input  logic [ST_W-1:0]   csr_wdata,
  output logic [ST_W-1:0]   status,
  output logic [LW-1:0]     ca_lw_flag,
  output logic [DLW-1:0]    d_lw_flag,
  output logic [CMD_W-1:0]  cap_lo_cmd,
  output logic [ADDR_W-1:0] cap_lo_addr,
  output logic [CMD_W-1:0]  cap_hi_cmd,
  output logic [ADDR_W-1:0] cap_hi_addr,
  output logic              hard_err_ack
);
  import bpel_pkg::*;

  // OR of the lanes that belong to half h (h=0 even, h=1 odd)
  function automatic logic half_any(input logic [LW-1:0] v, input int h);
    logic r;
    r = 1'b0;
    for (int i = 0; i < LW; i++) begin
      if ((i % 2) == h) r = r | v[i];
    end
    return r;
  endfunction

  // Named internal events
  logic [ST_W-1:0]   clr;
  logic [CMD_W-1:0]  tx_cmd;
  logic [ADDR_W-1:0] tx_addr;
  logic [1:0]        hit_ca, hit_rd, hit_wr, ext_hit_h, ext_busy_h, busy_h;
  logic [2:0]        err_h  [2];
  logic [2:0]        miss_h [2];
  logic [2:0]        clr_err_h  [2];
  logic [2:0]        clr_miss_h [2];
  logic [CMD_W-1:0]  cap_cmd_h  [2];
  logic [ADDR_W-1:0] cap_addr_h [2];
  logic [CMD_W-1:0]  ext_cmd;
  logic [1:0]        nack_q;
  logic              retry_q;
  logic              retry_bad;
  logic              data_logged;

  assign clr         = csr_we ? csr_wdata : '0;
  assign retry_bad   = retry_seen & ~retry_en;
  assign data_logged = d_valid & (d_is_rd | d_is_fill);
  assign ext_cmd     = nack_ca ? '0 : tx_cmd;
  assign ext_hit_h   = {1'b0, nack_ca | nack_wd};
  assign ext_busy_h  = {1'b0, |nack_q};

  // Command/address of the transaction whose data follows
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cmd  <= '0;
      tx_addr <= '0;
    end else if (ca_valid) begin
      tx_cmd  <= ca_cmd;
      tx_addr <= ca_addr;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign hit_ca[h] = ca_valid & half_any(ca_perr, h);
    assign hit_rd[h] = d_valid & d_is_rd   & half_any(d_perr, h);
    assign hit_wr[h] = d_valid & d_is_fill & half_any(d_perr, h);
    for (genvar k = 0; k < NKIND; k++) begin : g_kind
      assign clr_err_h[h][k]  = clr[err_bit(h, k)];
      assign clr_miss_h[h][k] = clr[miss_bit(h, k)];
    end
    bpel_half #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      ({hit_wr[h], hit_rd[h], hit_ca[h]}),
      .ext_hit  (ext_hit_h[h]),
      .ext_busy (ext_busy_h[h]),
      .ca_cmd   (ca_cmd),
      .ca_addr  (ca_addr),
      .tx_cmd   (tx_cmd),
      .tx_addr  (tx_addr),
      .ext_cmd  (ext_cmd),
      .clr_err  (clr_err_h[h]),
      .clr_miss (clr_miss_h[h]),
      .err      (err_h[h]),
      .miss     (miss_h[h]),
      .busy     (busy_h[h]),
      .cap_cmd  (cap_cmd_h[h]),
      .cap_addr (cap_addr_h[h])
    );
  end

  assign cap_lo_cmd  = cap_cmd_h[0];
  assign cap_lo_addr = cap_addr_h[0];
  assign cap_hi_cmd  = cap_cmd_h[1];
  assign cap_hi_addr = cap_addr_h[1];

  // Per-longword indicators
  logic [LW-1:0]  ca_set, ca_hold;
  logic [DLW-1:0] d_set, d_hold;

  for (genvar i = 0; i < LW; i++) begin : g_ca_lane
    assign ca_set[i]  = ca_valid & ca_perr[i];
    assign ca_hold[i] = err_h[i % 2][KIND_CA] & ~clr[err_bit(i % 2, KIND_CA)];
  end

  for (genvar b = 0; b < NBEAT; b++) begin : g_beat
    for (genvar j = 0; j < LW; j++) begin : g_lane
      assign d_set[b*LW + j]  = data_logged & (d_beat == BEAT_W'(b)) & d_perr[j];
      assign d_hold[b*LW + j] =
          (err_h[j % 2][KIND_RD] & ~clr[err_bit(j % 2, KIND_RD)]) |
          (err_h[j % 2][KIND_WR] & ~clr[err_bit(j % 2, KIND_WR)]);
    end
  end

  bpel_flags #(.N(LW)) u_ca_flags (
    .clk (clk), .rst_n (rst_n), .set (ca_set), .hold (ca_hold), .flags (ca_lw_flag)
  );

  bpel_flags #(.N(DLW)) u_d_flags (
    .clk (clk), .rst_n (rst_n), .set (d_set), .hold (d_hold), .flags (d_lw_flag)
  );

  bpel_sticky #(.N(2)) u_nack (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({nack_wd, nack_ca}),
    .clr   (clr[ST_NACK_WD:ST_NACK_CA]),
    .q     (nack_q)
  );

  bpel_sticky #(.N(1)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (retry_bad),
    .clr   (clr[ST_RETRY]),
    .q     (retry_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hard_err_ack <= 1'b0;
    else        hard_err_ack <= retry_bad;
  end

  always_comb begin
    status = '0;
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < NKIND; k++) begin
        status[err_bit(h, k)]  = err_h[h][k];
        status[miss_bit(h, k)] = miss_h[h][k];
      end
    end
    status[ST_NACK_CA] = nack_q[0];
    status[ST_NACK_WD] = nack_q[1];
    status[ST_RETRY]   = retry_q;
  end
endmodule

// File: rtl/bpel_chk.sv
module bpel_chk #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int LW     = 4,
  parameter int ST_W   = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic [ST_W-1:0]   status,
  input logic              ca_valid,
  input logic [LW-1:0]     ca_perr,
  input logic              d_valid,
  input logic              d_is_rd,
  input logic              d_is_fill,
  input logic              retry_seen,
  input logic              retry_en,
  input logic              hard_err_ack,
  input logic [LW-1:0]     ca_lw_flag,
  input logic [CMD_W-1:0]  cap_lo_cmd,
  input logic [ADDR_W-1:0] cap_lo_addr,
  input logic              lo_busy
);
  function automatic logic [LW-1:0] even_mask();
    logic [LW-1:0] m;
    for (int i = 0; i < LW; i++) m[i] = ((i % 2) == 0);
    return m;
  endfunction

  localparam logic [LW-1:0] EVEN = even_mask();

  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> ((status & $past(status)) == $past(status)));

  assert_ca_logged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_valid && |(ca_perr & EVEN)) |=> status[0]);

  assert_capture_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_busy && !csr_we) |=> ($stable(cap_lo_addr) && $stable(cap_lo_cmd)));

  assert_flag_needs_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ca_lw_flag & EVEN)) |-> status[0]);

  assert_untagged_data_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_is_rd && !d_is_fill) |=> !(status[2] && !$past(status[2])));

  assert_retry_fail_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_seen && !retry_en) |=> (hard_err_ack && status[14]));

  assert_ack_only_on_retry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_seen && !retry_en) |=> !hard_err_ack);
endmodule

bind bpel_logger bpel_chk #(
  .ADDR_W (ADDR_W),
  .CMD_W  (CMD_W),
  .LW     (LW),
  .ST_W   (ST_W)
) u_bpel_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_we       (csr_we),
  .status       (status),
  .ca_valid     (ca_valid),
  .ca_perr      (ca_perr),
  .d_valid      (d_valid),
  .d_is_rd      (d_is_rd),
  .d_is_fill    (d_is_fill),
  .retry_seen   (retry_seen),
  .retry_en     (retry_en),
  .hard_err_ack (hard_err_ack),
  .ca_lw_flag   (ca_lw_flag),
  .cap_lo_cmd   (cap_lo_cmd),
  .cap_lo_addr  (cap_lo_addr),
  .lo_busy      (busy_h[0])
);

// File: tb/test_bpel_logger.sv
module test_bpel_logger;
  localparam int ADDR_W = 32;
  localparam int CMD_W  = 4;
  localparam int LW     = 4;
  localparam int NBEAT  = 2;
  localparam int ST_W   = 15;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ca_valid = 1'b0;
  logic [CMD_W-1:0]  ca_cmd = '0;
  logic [ADDR_W-1:0] ca_addr = '0;
  logic [LW-1:0]     ca_perr = '0;
  logic              d_valid = 1'b0;
  logic [0:0]        d_beat = '0;
  logic [LW-1:0]     d_perr = '0;
  logic              d_is_rd = 1'b0, d_is_fill = 1'b0;
  logic              nack_ca = 1'b0, nack_wd = 1'b0;
  logic              retry_seen = 1'b0, retry_en = 1'b0;
  logic              csr_we = 1'b0;
  logic [ST_W-1:0]   csr_wdata = '0;
  logic [ST_W-1:0]   status;
  logic [LW-1:0]     ca_lw_flag;
  logic [LW*NBEAT-1:0] d_lw_flag;
  logic [CMD_W-1:0]  cap_lo_cmd, cap_hi_cmd;
  logic [ADDR_W-1:0] cap_lo_addr, cap_hi_addr;
  logic              hard_err_ack;

  always #4 clk = ~clk;

  bpel_logger #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .LW(LW), .NBEAT(NBEAT)) i_bpel_logger (
    .clk, .rst_n, .ca_valid, .ca_cmd, .ca_addr, .ca_perr, .d_valid, .d_beat, .d_perr,
    .d_is_rd, .d_is_fill, .nack_ca, .nack_wd, .retry_seen, .retry_en, .csr_we,
    .csr_wdata, .status, .ca_lw_flag, .d_lw_flag, .cap_lo_cmd, .cap_lo_addr,
    .cap_hi_cmd, .cap_hi_addr, .hard_err_ack
  );

  // Observation selectors
  localparam int SEL_ST = 0, SEL_CAF = 1, SEL_DF = 2, SEL_LO = 3, SEL_HI = 4, SEL_ACK = 5;

  logic [63:0] exp_q [$];
  int          sel_q [$];
  string       tag_q [$];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  function automatic logic [63:0] observe(input int sel);
    case (sel)
      SEL_ST:  return 64'(status);
      SEL_CAF: return 64'(ca_lw_flag);
      SEL_DF:  return 64'(d_lw_flag);
      SEL_LO:  return 64'({cap_lo_cmd, cap_lo_addr});
      SEL_HI:  return 64'({cap_hi_cmd, cap_hi_addr});
      default: return 64'(hard_err_ack);
    endcase
  endfunction

  function automatic logic [63:0] cap(input logic [CMD_W-1:0] c, input logic [ADDR_W-1:0] a);
    return 64'({c, a});
  endfunction

  // Driver side: push an expected item
  task automatic expect_v(input string tag, input int sel, input logic [63:0] v);
    exp_q.push_back(v);
    sel_q.push_back(sel);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares on the falling edge, away from the active edge
  always @(negedge clk) begin
    while (exp_q.size() != 0) begin
      logic [63:0] e, a;
      int s;
      string t;
      e = exp_q.pop_front();
      s = sel_q.pop_front();
      t = tag_q.pop_front();
      a = observe(s);
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", t, s, a, e);
      end
    end
  end

  // One clock with the current inputs; pulses are dropped afterwards
  task automatic step();
    @(posedge clk);
    #1;
    ca_valid = 0; ca_perr = '0; d_valid = 0; d_perr = '0; d_is_rd = 0; d_is_fill = 0;
    nack_ca = 0; nack_wd = 0; retry_seen = 0; csr_we = 0; csr_wdata = '0;
  endtask

  task automatic ca_cycle(input logic [CMD_W-1:0] c, input logic [ADDR_W-1:0] a,
                          input logic [LW-1:0] pe);
    ca_valid = 1; ca_cmd = c; ca_addr = a; ca_perr = pe;
  endtask

  task automatic data_cycle(input logic b, input logic [LW-1:0] pe, input logic rd,
                            input logic fill);
    d_valid = 1; d_beat = b; d_perr = pe; d_is_rd = rd; d_is_fill = fill;
  endtask

  task automatic clear_all();
    csr_we = 1; csr_wdata = '1;
    step();
    expect_v("R1 clear all", SEL_ST, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_v("R1 reset status", SEL_ST, 64'h0);
    expect_v("R1 reset ca flags", SEL_CAF, 64'h0);
    expect_v("R1 reset data flags", SEL_DF, 64'h0);
    expect_v("R1 reset cap lo", SEL_LO, 64'h0);
    expect_v("R1 reset cap hi", SEL_HI, 64'h0);
    expect_v("R1 reset ack", SEL_ACK, 64'h0);
    @(negedge clk);

    // R3: C/A error on longword 0 -> low half
    ca_cycle(4'h5, 32'h0000_00A1, 4'b0001); step();
    expect_v("R3 ca lo status", SEL_ST, 64'h0001);
    expect_v("R3 ca lo capture", SEL_LO, cap(4'h5, 32'h0000_00A1));
    expect_v("R5 ca flag lw0", SEL_CAF, 64'h1);
    @(negedge clk);

    // R2: odd longword goes to the high half
    ca_cycle(4'h6, 32'h0000_00A2, 4'b1000); step();
    expect_v("R2 ca hi status", SEL_ST, 64'h0041);
    expect_v("R2 ca hi capture", SEL_HI, cap(4'h6, 32'h0000_00A2));
    expect_v("R2 lo untouched", SEL_LO, cap(4'h5, 32'h0000_00A1));
    @(negedge clk);

    // R4: low half occupied -> missed, capture kept
    ca_cycle(4'h7, 32'h0000_00A3, 4'b0100); step();
    expect_v("R4 missed bit", SEL_ST, 64'h0043);
    expect_v("R4 capture kept", SEL_LO, cap(4'h5, 32'h0000_00A1));
    expect_v("R5 flags accumulate", SEL_CAF, 64'hD);
    @(negedge clk);

    // R1: clearing only the missed bit
    csr_we = 1; csr_wdata = 15'h0002; step();
    expect_v("R1 partial clear", SEL_ST, 64'h0041);
    expect_v("R5 flags held", SEL_CAF, 64'hD);
    @(negedge clk);

    // R5: clearing the low summary drops only low-lane flags
    csr_we = 1; csr_wdata = 15'h0001; step();
    expect_v("R1 summary cleared", SEL_ST, 64'h0040);
    expect_v("R5 lo flags dropped", SEL_CAF, 64'h8);
    @(negedge clk);

    // R6: released capture takes the next error
    ca_cycle(4'h8, 32'h0000_00A4, 4'b0001); step();
    expect_v("R6 recapture status", SEL_ST, 64'h0041);
    expect_v("R6 recapture", SEL_LO, cap(4'h8, 32'h0000_00A4));
    @(negedge clk);
    clear_all();
    @(negedge clk);

    // R8: read data error uses last C/A; beat 1 lane 2 -> flag 6
    ca_cycle(4'h3, 32'h0000_0B01, 4'b0000); step();
    expect_v("R3 clean ca no log", SEL_ST, 64'h0);
    @(negedge clk);
    data_cycle(1'b1, 4'b0100, 1'b1, 1'b0); step();
    expect_v("R7 read error logged", SEL_ST, 64'h0004);
    expect_v("R8 read capture", SEL_LO, cap(4'h3, 32'h0000_0B01));
    expect_v("R5 data flag beat1 lw2", SEL_DF, 64'h40);
    @(negedge clk);

    // R7: untagged data errors are ignored
    data_cycle(1'b0, 4'b1111, 1'b0, 1'b0); step();
    expect_v("R7 ignored status", SEL_ST, 64'h0004);
    expect_v("R7 ignored flags", SEL_DF, 64'h40);
    expect_v("R7 ignored hi cap", SEL_HI, cap(4'h6, 32'h0000_00A2));
    @(negedge clk);

    // R7/R2: fill write error on odd lane -> high half write bit
    data_cycle(1'b0, 4'b0010, 1'b0, 1'b1); step();
    expect_v("R7 fill error logged", SEL_ST, 64'h0404);
    expect_v("R8 fill capture hi", SEL_HI, cap(4'h3, 32'h0000_0B01));
    expect_v("R5 data flag beat0 lw1", SEL_DF, 64'h42);
    @(negedge clk);
    clear_all();
    expect_v("R5 data flags cleared", SEL_DF, 64'h0);
    @(negedge clk);

    // R9: C/A and read errors in one cycle, same half
    ca_cycle(4'h9, 32'h0000_0C01, 4'b0001);
    data_cycle(1'b0, 4'b0001, 1'b1, 1'b0);
    step();
    expect_v("R9 priority status", SEL_ST, 64'h000D);
    expect_v("R9 ca wins capture", SEL_LO, cap(4'h9, 32'h0000_0C01));
    @(negedge clk);
    clear_all();
    @(negedge clk);

    // R10: no-ack logging
    nack_ca = 1; step();
    expect_v("R10 nack ca bit", SEL_ST, 64'h1000);
    expect_v("R10 nack ca capture", SEL_LO, cap(4'h0, 32'h0000_0C01));
    @(negedge clk);
    nack_wd = 1; step();
    expect_v("R10 nack wd no miss", SEL_ST, 64'h3000);
    expect_v("R10 capture kept", SEL_LO, cap(4'h0, 32'h0000_0C01));
    @(negedge clk);
    clear_all();
    @(negedge clk);
    nack_wd = 1; step();
    expect_v("R10 nack wd bit", SEL_ST, 64'h2000);
    expect_v("R10 nack wd capture", SEL_LO, cap(4'h9, 32'h0000_0C01));
    @(negedge clk);
    clear_all();
    @(negedge clk);

    // R11: retry handling
    retry_en = 1; retry_seen = 1; step();
    expect_v("R11 enabled retry status", SEL_ST, 64'h0);
    expect_v("R11 enabled retry ack", SEL_ACK, 64'h0);
    @(negedge clk);
    retry_en = 0; retry_seen = 1; step();
    expect_v("R11 retry fail bit", SEL_ST, 64'h4000);
    expect_v("R11 hard ack", SEL_ACK, 64'h1);
    @(negedge clk);
    step();
    expect_v("R11 ack one cycle", SEL_ACK, 64'h0);
    expect_v("R11 bit sticky", SEL_ST, 64'h4000);
    @(negedge clk);
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule